// File: doc/BRIEF.md
# Address Line Mirror Tester

This block is a self-running sequencer that looks for broken memory address lines. A broken line makes two different addresses land on one physical word, so a write to one of them also changes the other. The block holds a test address fixed and produces partner addresses from it by flipping a single address bit. The bit starts at the first bit above the byte offset inside a word and moves up one position per probe. Partners outside the region under test are skipped.

For each partner inside the region, the block reads the partner word and writes the bitwise inverse of that value into the test address. It then reads the partner again and reads the test address again, both from memory. If the two reads match, the write to the test address reached the partner, and the block reports an error. The block makes one sweep with the test address at the bottom of the region. If that sweep finds no error, it makes a second sweep with the test address at the last word of the region. All memory traffic uses a single request/acknowledge port. Software starts a run with a start pulse and gets a done pulse with a pass flag.

Top module: `addr_mirror_tester`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `err_valid` and `mem_req` are all 0.
- R2: In each sweep, the flip mask starts at the word size in bytes (4 for 32-bit words). It doubles for each candidate and stops after the highest address bit. A full region of 2^AW bytes therefore gets AW−log2(word bytes) probes per sweep, and every access is word aligned.
- R3: A partner is probed only when it is at or above `base_addr` and below `base_addr + region_size`. No memory access ever falls outside that range. `base_addr` and `region_size` must be word aligned and held steady while `busy` is 1.
- R4: Each probe makes exactly four accesses in this order: read the partner, write the inverse of the value just read to the test address, read the partner again, read the test address.
- R5: A probe fails when the second partner read equals the test-address read. On a failing probe, `err_valid` pulses for one cycle. At the same time, `err_test_addr` holds the test address, `err_partner_addr` holds the partner address, and `err_mask` holds the flipped bit as a one-hot value.
- R6: The first sweep uses the test address `base_addr`. The second sweep uses `base_addr + region_size − word bytes`, and it runs only if the first sweep found no error.
- R7: At the end of a run, `done` pulses for one cycle with `busy` at 0. `pass` is 1 exactly when no probe in the run failed.
- R8: `mem_req` stays high until a cycle in which `mem_ack` is 1. While it waits, `mem_addr`, `mem_we` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a run when idle |
| base_addr | input | AW | Byte address of the region's first word |
| region_size | input | AW+1 | Region length in bytes |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run |
| err_valid | output | 1 | One-cycle pulse per failing probe |
| err_test_addr | output | AW | Test address of the failing probe |
| err_partner_addr | output | AW | Partner address of the failing probe |
| err_mask | output | AW | One-hot flipped bit of the failing probe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access completes; read data is valid in this cycle |
| mem_rdata | input | DW | Read data |

## Verification
The assertions check on every cycle that requests are held until acknowledged, that every access is word aligned and inside the region, that each error report has a one-hot mask with a partner exactly that one bit away from the test address, and that `done` is a single-cycle pulse. Only the bench scenarios can show the rest. These are:
- the number of probes in each sweep;
- the skipping of partners outside a narrow window;
- the four-access order, including the inverse written;
- detection of an injected alias on a chosen address bit;
- the second sweep being skipped after a failure.

// File: rtl/amt_pkg.sv
package amt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD_P1,
    ST_WR_T,
    ST_RD_P2,
    ST_RD_T,
    ST_NEXT
  } amt_state_e;
endpackage

// File: rtl/amt_mask_walk.sv
module amt_mask_walk #(
  parameter int AW = 12,
  parameter int LB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          step,
  input  logic [AW-1:0] test_addr,
  input  logic [AW-1:0] base_addr,
  input  logic [AW:0]   end_addr,
  output logic [AW:0]   mask,
  output logic          exhausted,
  output logic [AW-1:0] partner,
  output logic          in_range
);
  // One bit wider than the address so the walk ends cleanly at bit AW
  always_ff @(posedge clk) begin
    if (rst)       mask <= '0;
    else if (init) mask <= (AW+1)'(1) << LB;
    else if (step) mask <= mask << 1;
  end

  always_comb begin
    exhausted = mask[AW];
    partner   = test_addr ^ mask[AW-1:0];
    in_range  = (partner >= base_addr) && ({1'b0, partner} < end_addr);
  end
endmodule

// File: rtl/amt_mem_port.sv
module amt_mem_port #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          issue_we,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_wdata,
  output logic          rsp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (issue) begin
      mem_req   <= 1'b1;
      mem_we    <= issue_we;
      mem_addr  <= issue_addr;
      mem_wdata <= issue_wdata;
    end else if (mem_ack) begin
      mem_req   <= 1'b0;
    end
  end

  assign rsp = mem_req & mem_ack;
endmodule

// File: rtl/addr_mirror_tester.sv
module addr_mirror_tester #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW:0]   region_size,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          err_valid,
  output logic [AW-1:0] err_test_addr,
  output logic [AW-1:0] err_partner_addr,
  output logic [AW-1:0] err_mask,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  import amt_pkg::*;

  localparam int WB = DW / 8;
  localparam int LB = $clog2(WB);

  amt_state_e    state;
  logic          pend;
  logic          second;
  logic          fail;
  logic [AW-1:0] test_addr;
  logic [DW-1:0] p1_val;
  logic [DW-1:0] p2_val;

  logic [AW:0]   end_addr;
  logic [AW:0]   last_word;
  logic [AW:0]   mask;
  logic          exhausted;
  logic [AW-1:0] partner;
  logic          in_range;
  logic          init;
  logic          step;
  logic          issue;
  logic          issue_we;
  logic [AW-1:0] issue_addr;
  logic [DW-1:0] issue_wdata;
  logic          rsp;

  assign end_addr  = {1'b0, base_addr} + region_size;
  assign last_word = end_addr - (AW+1)'(WB);

  amt_mask_walk #(.AW(AW), .LB(LB)) u_walk (
    .clk(clk), .rst(rst), .init(init), .step(step),
    .test_addr(test_addr), .base_addr(base_addr), .end_addr(end_addr),
    .mask(mask), .exhausted(exhausted), .partner(partner), .in_range(in_range)
  );

  amt_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .issue(issue), .issue_we(issue_we),
    .issue_addr(issue_addr), .issue_wdata(issue_wdata), .rsp(rsp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
  );

  // Control decode for the walker and the access port
  always_comb begin
    init        = 1'b0;
    step        = 1'b0;
    issue       = 1'b0;
    issue_we    = 1'b0;
    issue_addr  = partner;
    issue_wdata = ~p1_val;
    unique case (state)
      ST_IDLE:  init = start;
      ST_CHECK: begin
        if (exhausted) init = !second && !fail;
        else           step = !in_range;
      end
      ST_RD_P1: issue = !pend;
      ST_WR_T: begin
        issue      = !pend;
        issue_we   = 1'b1;
        issue_addr = test_addr;
      end
      ST_RD_P2: issue = !pend;
      ST_RD_T: begin
        issue      = !pend;
        issue_addr = test_addr;
      end
      ST_NEXT:  step = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= ST_IDLE;
      pend             <= 1'b0;
      second           <= 1'b0;
      fail             <= 1'b0;
      test_addr        <= '0;
      p1_val           <= '0;
      p2_val           <= '0;
      busy             <= 1'b0;
      done             <= 1'b0;
      pass             <= 1'b0;
      err_valid        <= 1'b0;
      err_test_addr    <= '0;
      err_partner_addr <= '0;
      err_mask         <= '0;
    end else begin
      done      <= 1'b0;
      err_valid <= 1'b0;
      if (issue)    pend <= 1'b1;
      else if (rsp) pend <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          test_addr <= base_addr;
          second    <= 1'b0;
          fail      <= 1'b0;
          busy      <= 1'b1;
          pass      <= 1'b0;
          state     <= ST_CHECK;
        end
        ST_CHECK: begin
          if (exhausted) begin
            if (!second && !fail) begin
              second    <= 1'b1;
              test_addr <= last_word[AW-1:0];
            end else begin
              busy  <= 1'b0;
              done  <= 1'b1;
              pass  <= !fail;
              state <= ST_IDLE;
            end
          end else if (in_range) begin
            state <= ST_RD_P1;
          end
        end
        ST_RD_P1: if (rsp) begin
          p1_val <= mem_rdata;
          state  <= ST_WR_T;
        end
        ST_WR_T: if (rsp) state <= ST_RD_P2;
        ST_RD_P2: if (rsp) begin
          p2_val <= mem_rdata;
          state  <= ST_RD_T;
        end
        ST_RD_T: if (rsp) begin
          if (mem_rdata == p2_val) begin
            fail             <= 1'b1;
            err_valid        <= 1'b1;
            err_test_addr    <= test_addr;
            err_partner_addr <= partner;
            err_mask         <= mask[AW-1:0];
          end
          state <= ST_NEXT;
        end
        ST_NEXT: state <= ST_CHECK;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amt_checker.sv
module amt_checker #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] base_addr,
  input logic [AW:0]   region_size,
  input logic          busy,
  input logic          done,
  input logic          err_valid,
  input logic [AW-1:0] err_test_addr,
  input logic [AW-1:0] err_partner_addr,
  input logic [AW-1:0] err_mask,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  localparam int LB = $clog2(DW / 8);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[LB-1:0] == '0));

  p_in_region_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((mem_addr >= base_addr)
                 && ({1'b0, mem_addr} < ({1'b0, base_addr} + region_size))));

  p_err_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> ($onehot(err_mask) && ((err_test_addr ^ err_partner_addr) == err_mask)));

  p_err_busy_r5: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> busy);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind addr_mirror_tester amt_checker #(.AW(AW), .DW(DW)) u_amt_checker (
  .clk(clk), .rst(rst), .base_addr(base_addr), .region_size(region_size),
  .busy(busy), .done(done), .err_valid(err_valid), .err_test_addr(err_test_addr),
  .err_partner_addr(err_partner_addr), .err_mask(err_mask), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/test_addr_mirror_tester.sv
module test_addr_mirror_tester;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int LB = 2;
  localparam int NW = 1 << (AW - LB);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW:0]   region_size = '0;
  logic          busy, done, pass, err_valid;
  logic [AW-1:0] err_test_addr, err_partner_addr, err_mask;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  addr_mirror_tester #(.AW(AW), .DW(DW)) i_addr_mirror_tester (.*);

  int total = 0;
  int bad = 0;

  // Memory model with an optional address-line alias (word index bits forced low)
  logic [DW-1:0]     mem [NW];
  logic [AW-LB-1:0]  fault = '0;
  int                n_acc = 0, n_oor = 0, n_order = 0, n_err = 0;
  int                phase = 0;
  logic [AW-1:0]     ph_partner, ph_test;
  logic [DW-1:0]     ph_rd;
  logic [AW-1:0]     last_et, last_ep, last_em;

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      automatic int idx = int'(mem_addr[AW-1:LB] & ~fault);
      mem_ack <= 1'b1;
      n_acc   <= n_acc + 1;
      if ({1'b0, mem_addr} < {1'b0, base_addr} || {1'b0, mem_addr} >= {1'b0, base_addr} + region_size)
        n_oor <= n_oor + 1;
      case (phase)
        0: begin
          if (mem_we) n_order <= n_order + 1;
          ph_partner <= mem_addr; ph_rd <= mem[idx];
        end
        1: begin
          if (!mem_we || mem_wdata != ~ph_rd) n_order <= n_order + 1;
          ph_test <= mem_addr;
        end
        2: if (mem_we || mem_addr != ph_partner) n_order <= n_order + 1;
        default: if (mem_we || mem_addr != ph_test) n_order <= n_order + 1;
      endcase
      phase <= (phase + 1) % 4;
      if (mem_we) mem[idx] <= mem_wdata;
      else        mem_rdata <= mem[idx];
    end else begin
      mem_ack <= 1'b0;
    end
    if (err_valid) begin
      n_err   <= n_err + 1;
      last_et <= err_test_addr;
      last_ep <= err_partner_addr;
      last_em <= err_mask;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] b, input logic [AW:0] s, input logic [AW-LB-1:0] f);
    @(negedge clk);
    for (int i = 0; i < NW; i++) mem[i] = DW'(i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    fault = f; base_addr = b; region_size = s;
    n_acc = 0; n_oor = 0; n_order = 0; n_err = 0; phase = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    chk("R7 done seen", int'(done), 1);
    chk("R7 busy low at done", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 pass", int'(pass), 0);
    chk("R1 err_valid", int'(err_valid), 0);
    chk("R1 mem_req", int'(mem_req), 0);
  endtask

  task automatic t_healthy_full();
    run(12'h000, 13'h1000, '0);
    chk("R7 pass healthy", int'(pass), 1);
    chk("R5 no errors", n_err, 0);
    chk("R2 R6 accesses two sweeps x10 probes", n_acc, 80);
    chk("R4 access order", n_order, 0);
    chk("R3 out of range", n_oor, 0);
  endtask

  task automatic t_window();
    run(12'h100, 13'h0200, '0);
    chk("R3 window accesses 12 probes", n_acc, 48);
    chk("R3 window out of range", n_oor, 0);
    chk("R4 window order", n_order, 0);
    chk("R7 window pass", int'(pass), 1);
  endtask

  task automatic t_alias_bit5();
    run(12'h000, 13'h1000, 10'h008);
    chk("R7 alias pass low", int'(pass), 0);
    chk("R5 one error", n_err, 1);
    chk("R5 err test addr", int'(last_et), 'h000);
    chk("R5 err partner addr", int'(last_ep), 'h020);
    chk("R5 err mask", int'(last_em), 'h020);
    chk("R6 second sweep skipped", n_acc, 40);
  endtask

  task automatic t_alias_skipped();
    run(12'h100, 13'h0200, 10'h080);
    chk("R3 bit9 alias outside probes", int'(pass), 1);
    chk("R3 bit9 no errors", n_err, 0);
  endtask

  task automatic t_alias_top();
    run(12'h000, 13'h1000, 10'h200);
    chk("R2 top bit err mask", int'(last_em), 'h800);
    chk("R2 top bit partner", int'(last_ep), 'h800);
    chk("R5 top bit one error", n_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_healthy_full();
    t_window();
    t_alias_bit5();
    t_alias_skipped();
    t_alias_top();
    t_healthy_full();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule